// File: doc/BRIEF.md
# Phase Frequency Detector with Antibacklash

This block compares the phase of a divided reference clock against a divided feedback clock and issues two pump-control pulses, `up` and `dn`. A rising edge on the reference input sets `up`, and a rising edge on the feedback input sets `dn`. Once both are set, a programmable reset window of `abl_cycles + 1` system clock cycles runs, and then both outputs clear in the same cycle. Because of this window, a pulse of minimum width appears on both outputs even when the two inputs rise in the same cycle. This removes the dead zone near zero phase error. The leading output stays high longer than the lagging one, and the difference equals the phase error in system clock cycles.

Both divided inputs must be synchronous to `clk`. Each one passes through a rising-edge detector. A control state machine has four states:
- `PFD_IDLE`: both outputs low.
- `PFD_UP`: only `up` high.
- `PFD_DN`: only `dn` high.
- `PFD_BOTH`: both outputs high while the reset window counts.

The transitions are:
- IDLE→UP on a reference edge alone.
- IDLE→DN on a feedback edge alone.
- IDLE→BOTH on both edges in the same cycle.
- UP→BOTH on a feedback edge.
- DN→BOTH on a reference edge.
- BOTH→IDLE, BOTH→UP, BOTH→DN or BOTH→BOTH when the window ends. The target depends on which edges arrived during the window and are held as pending.

In every other case the state is kept. The charge pump and the loop filter sit outside this block.

Top module: `pfd_antibacklash`

## Requirements
- R1: While `rst_n` is low and right after reset, `up` and `dn` are both 0.
- R2: A rising edge on `ref_div` with `dn` low and no window running drives `up` to 1 on the next clock, with `dn` still 0.
- R3: A rising edge on `fb_div` with `up` low and no window running drives `dn` to 1 on the next clock, with `up` still 0.
- R4: A further rising edge on an input whose output is already high, and a level held high, have no effect on that output's pulse width.
- R5: Once `up` and `dn` are both high, they stay high together for exactly `abl_cycles + 1` clocks and then fall in the same cycle.
- R6: With `abl_cycles` equal to 0, both outputs clear on the clock right after they were both set, giving a one-cycle coincident pulse.
- R7: Rising edges on both inputs in the same cycle make `up` and `dn` rise together, each with a width of `abl_cycles + 1`.
- R8: When one input leads the other by k cycles, the leading output is high for k + `abl_cycles` + 1 cycles and the lagging output for `abl_cycles` + 1.
- R9: A rising edge that arrives while the reset window runs is held. When the window ends, the matching output stays high while the other clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Divided reference clock, synchronous to clk |
| fb_div | input | 1 | Divided feedback clock, synchronous to clk |
| abl_cycles | input | ABL_W | Reset window length minus one, in clk cycles |
| up | output | 1 | Pump-up control pulse |
| dn | output | 1 | Pump-down control pulse |

## Verification
The bench drives the following input patterns and measures both pulse widths in each:
- Reference leading: separates edge-to-output latency from width arithmetic.
- Feedback leading: shows the two paths are symmetric.
- Same-cycle edges: proves that no dead zone appears at zero phase error.
- A zero window: exposes an off-by-one in the clear counter.
- A second reference edge while `up` is already high: tells an input that is correctly ignored apart from one that restarts the pulse.
- A reference edge inside the reset window: tells a pending capture apart from a lost edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2,
        PFD_BOTH = 2'd3
    } pfd_state_e;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;

    // R4: a held level yields a single edge event
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!run || done) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // R5: the window is not abandoned before the count completes
    assert_window_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> run);
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    input  logic clr_done,
    output logic up,
    output logic dn,
    output logic in_both
);
    pfd_state_e state, state_nx;
    logic ref_pend, fb_pend;
    logic ref_any, fb_any;

    assign ref_any = ref_pend | ref_rise;
    assign fb_any  = fb_pend  | fb_rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            PFD_IDLE: begin
                if (ref_rise && fb_rise) state_nx = PFD_BOTH;
                else if (ref_rise)       state_nx = PFD_UP;
                else if (fb_rise)        state_nx = PFD_DN;
            end
            PFD_UP: if (fb_rise)  state_nx = PFD_BOTH;
            PFD_DN: if (ref_rise) state_nx = PFD_BOTH;
            PFD_BOTH: begin
                if (clr_done) begin
                    if (ref_any && fb_any) state_nx = PFD_BOTH;
                    else if (ref_any)      state_nx = PFD_UP;
                    else if (fb_any)       state_nx = PFD_DN;
                    else                   state_nx = PFD_IDLE;
                end
            end
            default: state_nx = PFD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PFD_IDLE;
            ref_pend <= 1'b0;
            fb_pend  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == PFD_BOTH && !clr_done) begin
                ref_pend <= ref_any;
                fb_pend  <= fb_any;
            end else begin
                ref_pend <= 1'b0;
                fb_pend  <= 1'b0;
            end
        end
    end

    always_comb begin
        up      = (state == PFD_UP) || (state == PFD_BOTH);
        dn      = (state == PFD_DN) || (state == PFD_BOTH);
        in_both = (state == PFD_BOTH);
    end

    assert_up_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PFD_IDLE && ref_rise && !fb_rise) |=> (up && !dn));
    assert_dn_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PFD_IDLE && fb_rise && !ref_rise) |=> (dn && !up));
    assert_joint_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn && !clr_done) |=> (up && dn));
    assert_pending_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PFD_BOTH && clr_done && ref_pend) |=> up);
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash #(
    parameter int ABL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_div,
    input  logic             fb_div,
    input  logic [ABL_W-1:0] abl_cycles,
    output logic             up,
    output logic             dn
);
    logic ref_rise, fb_rise, win_run, win_done;

    pfd_edge_det u_ref_edge (.clk(clk), .rst_n(rst_n), .sig_in(ref_div), .rise(ref_rise));
    pfd_edge_det u_fb_edge  (.clk(clk), .rst_n(rst_n), .sig_in(fb_div),  .rise(fb_rise));

    pfd_abl_timer #(.CNT_W(ABL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(win_run), .limit(abl_cycles), .done(win_done)
    );

    pfd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .clr_done(win_done), .up(up), .dn(dn), .in_both(win_run)
    );

    // R6: zero window clears on the next clock unless both edges re-arrive
    assert_zero_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn && $past(!(up && dn)) && abl_cycles == '0 && !(ref_rise && fb_rise))
        |=> !(up && dn));
endmodule

// File: tb/pfd_antibacklash_tb.sv
`timescale 1ns/1ps
module pfd_antibacklash_tb;
    localparam int ABL_W = 6;
    localparam int N = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0;
    logic fb_div = 1'b0;
    logic [ABL_W-1:0] abl_cycles = '0;
    logic up, dn;

    int n_tests = 0;
    int n_fail = 0;
    logic [N-1:0] up_h, dn_h;

    always #4 clk = ~clk;

    pfd_antibacklash #(.ABL_W(ABL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .abl_cycles(abl_cycles), .up(up), .dn(dn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] span(input int from, input int to);
        logic [N-1:0] w = '0;
        for (int i = from; i < to; i++) w[i] = 1'b1;
        return w;
    endfunction

    function automatic int ones(input logic [N-1:0] w);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(w[i]);
        return c;
    endfunction

    function automatic int first1(input logic [N-1:0] w);
        for (int i = 0; i < N; i++) if (w[i]) return i;
        return -1;
    endfunction

    function automatic int last1(input logic [N-1:0] w);
        int l = -1;
        for (int i = 0; i < N; i++) if (w[i]) l = i;
        return l;
    endfunction

    // sample outputs then drive the inputs for that cycle, on each falling edge
    task automatic run_waves(input logic [N-1:0] rw, input logic [N-1:0] fw, input int abl);
        abl_cycles = ABL_W'(abl);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            up_h[i] = up;
            dn_h[i] = dn;
            ref_div = rw[i];
            fb_div  = fw[i];
        end
        ref_div = 1'b0;
        fb_div  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!up && !dn, "R1 in reset", {up, dn}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!up && !dn, "R1 after reset", {up, dn}, 0);
    endtask

    task automatic t_ref_lead();
        run_waves(span(0, 20), span(3, 20), 2);
        chk(first1(up_h) == 1, "R2 up latency", first1(up_h), 1);
        chk(dn_h[1] == 1'b0, "R2 dn stays low", dn_h[1], 0);
        chk(ones(up_h) == 6, "R8 lead width", ones(up_h), 6);
        chk(ones(dn_h) == 3, "R5 window width", ones(dn_h), 3);
        chk(last1(up_h) == last1(dn_h), "R5 joint clear", last1(up_h), last1(dn_h));
    endtask

    task automatic t_fb_lead();
        run_waves(span(5, 20), span(0, 20), 1);
        chk(first1(dn_h) == 1 && up_h[1] == 1'b0, "R3 dn latency", first1(dn_h), 1);
        chk(ones(dn_h) == 7, "R8 fb lead width", ones(dn_h), 7);
        chk(ones(up_h) == 2, "R8 lag width", ones(up_h), 2);
    endtask

    task automatic t_in_phase();
        run_waves(span(0, 20), span(0, 20), 3);
        chk(first1(up_h) == 1 && first1(dn_h) == 1, "R7 joint rise", first1(dn_h), 1);
        chk(ones(up_h) == 4 && ones(dn_h) == 4, "R7 width", ones(up_h), 4);
    endtask

    task automatic t_zero_window();
        run_waves(span(0, 20), span(0, 20), 0);
        chk(ones(up_h) == 1 && ones(dn_h) == 1, "R6 in-phase width", ones(up_h), 1);
        run_waves(span(0, 20), span(2, 20), 0);
        chk(ones(up_h) == 3, "R6 lead width", ones(up_h), 3);
        chk(ones(dn_h) == 1, "R6 lag width", ones(dn_h), 1);
    endtask

    task automatic t_retrigger();
        run_waves(span(0, 2) | span(3, 20), span(6, 20), 2);
        chk(ones(up_h) == 9, "R4 retrigger ignored", ones(up_h), 9);
        chk(ones(dn_h) == 3, "R4 dn width", ones(dn_h), 3);
    endtask

    task automatic t_pending();
        run_waves(span(0, 2) | span(3, 20), span(0, 2) | span(10, 20), 4);
        chk(dn_h[5] && !dn_h[6], "R9 dn clears after window", dn_h[6], 0);
        chk(up_h[6] == 1'b1, "R9 held edge keeps up", up_h[6], 1);
        chk(ones(up_h) == 15 && last1(up_h) == 15, "R9 up width", ones(up_h), 15);
        chk(ones(dn_h) == 10, "R9 dn total", ones(dn_h), 10);
    endtask

    initial begin
        #(8ns * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ref_lead();
        t_fb_lead();
        t_in_phase();
        t_zero_window();
        t_retrigger();
        t_pending();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule